// File: doc/BRIEF.md
# Multi-Block Fetch Return Address Stack

This block predicts return targets for an instruction front end that fetches up to four basic blocks in one cycle. Each cycle the fetch stage presents a group: a 2-bit kind code and a return address for every block slot, in block order. Block 0 starts at the PC; the start address of each later block comes from other predictors. This block only tracks calls and returns. Every call in a kept block pushes its return address in that same cycle, in block order. A return that closes the group pops the newest address and presents it as the prediction, even when that address was pushed earlier in the same group.

A return or an indirect jump ends the group, and the blocks after it are dropped. An indirect jump also raises a termination flag and makes no prediction. The stack is a circular buffer. When it is full, a new push overwrites the oldest entry. The pointer and occupancy in force before each group are output as a checkpoint tag. On a misprediction the tag can be loaded back, which rewinds the pointer and the occupancy but not the entry contents.

Top module: `mbfras_top`

## Requirements
- R1: Every call (kind 2'b01) in a kept block pushes its return address in the same cycle. Pushes are applied in block order, so the call in the highest kept slot ends on top.
- R2: A return (kind 2'b10) in a kept block sets ret_pred_valid and drives ret_pred_addr with the newest address, counting pushes made by earlier blocks of the same group. That address is then removed from the stack.
- R3: The first return or indirect jump (kind 2'b11) is the last kept block. keep_mask bit i is 1 exactly for the slots up to and including that block. Calls after it push nothing.
- R4: An indirect jump that ends the group sets ind_end, produces no prediction and pops nothing.
- R5: The stack holds 16 entries. A push on a full stack overwrites the oldest entry, and the occupancy stays at 16.
- R6: A return when no entry is available (occupancy 0 and no earlier call in the group) gives ret_pred_valid=0 and leaves pointer and occupancy unchanged.
- R7: ckpt_ptr and ckpt_cnt show the top pointer and the occupancy in force before the current group.
- R8: When restore_valid is high, the pointer is loaded from restore_ptr and the occupancy from restore_cnt (values above 16 are clamped to 16). The group in that cycle is discarded: keep_mask is 0, and there is no push and no prediction.
- R9: After a synchronous reset the pointer and the occupancy are 0 and all group outputs are idle.
- R10: While grp_valid is low, the outputs are idle and the stack state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_valid | input | 1 | A fetch group is presented this cycle |
| blk_kind | input | 8 | Kind of slot i in bits [2i+1:2i]: 00 plain, 01 call, 10 return, 11 indirect jump |
| blk_ret_addr | input | 128 | Return address of slot i in bits [32i+31:32i] |
| restore_valid | input | 1 | Rewind the stack to the given tag |
| restore_ptr | input | 4 | Top pointer to restore |
| restore_cnt | input | 5 | Occupancy to restore |
| keep_mask | output | 4 | Slots kept in this group |
| ind_end | output | 1 | The group was closed by an indirect jump |
| ret_pred_valid | output | 1 | A return prediction is available |
| ret_pred_addr | output | 32 | Predicted return target |
| ckpt_ptr | output | 4 | Top pointer before this group |
| ckpt_cnt | output | 5 | Occupancy before this group |

## Verification
The assertions check, every cycle:
- the occupancy stays within the depth;
- the kept slots always form a prefix;
- an indirect-jump close never comes with a prediction;
- a restore loads the tag it was given;
- an idle cycle holds the state;
- a return with no same-cycle call shrinks the occupancy by one.

Only the bench scenarios can show that the predicted address is the right one. That covers the same-cycle bypass, the order of several pushes, overwriting the oldest entry on overflow, and the stack contents after a rewind. The bench shows these by comparing every cycle against a block-by-block reference model.

// File: rtl/mbfras_pkg.sv
// Shared types for the multi-block fetch return address stack.
package mbfras_pkg;
    // Kind code of one block slot inside a fetch group.
    typedef enum logic [1:0] {
        BK_SEQ  = 2'b00,
        BK_CALL = 2'b01,
        BK_RET  = 2'b10,
        BK_IND  = 2'b11
    } blk_kind_e;
endpackage

// File: rtl/mbfras_group_scan.sv
// Walks the block slots of one fetch group in order.
// Finds which slots are kept (up to and including the first return or
// indirect jump) and which kept slots push.
// Gives each push its slot offset, 1-based and counted in block order.
// Assumes grp_act already excludes restore cycles.
module mbfras_group_scan
    import mbfras_pkg::*;
#(
    parameter int NBLK = 4,
    parameter int AW   = 32,
    parameter int NW   = 3
) (
    input  logic                grp_act,
    input  logic [2*NBLK-1:0]   kinds,
    input  logic [AW*NBLK-1:0]  addrs,
    output logic [NBLK-1:0]     keep,
    output logic [NBLK-1:0]     push,
    output logic [NW*NBLK-1:0]  slot,
    output logic [NW-1:0]       npush,
    output logic                ret_hit,
    output logic                ind_hit,
    output logic [AW-1:0]       last_addr
);
    localparam logic [NW-1:0] ONE = {{(NW-1){1'b0}}, 1'b1};

    // Sequential walk over the slots, stopping at the first terminator.
    always_comb begin
        logic      open;
        logic [NW-1:0] cnt;
        blk_kind_e k;
        open      = grp_act;
        cnt       = '0;
        keep      = '0;
        push      = '0;
        slot      = '0;
        ret_hit   = 1'b0;
        ind_hit   = 1'b0;
        last_addr = '0;
        for (int i = 0; i < NBLK; i++) begin
            k = blk_kind_e'(kinds[2*i +: 2]);
            if (open) begin
                keep[i] = 1'b1;
                case (k)
                    BK_CALL: begin
                        cnt       = cnt + ONE;
                        push[i]   = 1'b1;
                        last_addr = addrs[AW*i +: AW];
                    end
                    BK_RET: begin
                        ret_hit = 1'b1;
                        open    = 1'b0;
                    end
                    BK_IND: begin
                        ind_hit = 1'b1;
                        open    = 1'b0;
                    end
                    default: ;
                endcase
            end
            slot[NW*i +: NW] = cnt;
        end
        npush = cnt;
    end
endmodule

// File: rtl/mbfras_stack_store.sv
// Entry storage of the circular return stack.
// Has NBLK write ports and one read port.
// When two ports hit the same entry, the higher slot wins. With NBLK no larger
// than the depth this never happens within one group.
// Entries have no reset; occupancy tracking decides whether they are meaningful.
module mbfras_stack_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    parameter int NBLK  = 4,
    parameter int PW    = 4
) (
    input  logic                clk,
    input  logic [NBLK-1:0]     wr_en,
    input  logic [PW*NBLK-1:0]  wr_idx,
    input  logic [AW*NBLK-1:0]  wr_data,
    input  logic [PW-1:0]       rd_idx,
    output logic [AW-1:0]       rd_data
);
    logic [AW-1:0] mem [DEPTH];

    // Apply the writes of all kept calls, in block order.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NBLK; i++) begin
            if (wr_en[i]) mem[wr_idx[PW*i +: PW]] <= wr_data[AW*i +: AW];
        end
    end

    // Asynchronous read of the entry at the current top.
    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/mbfras_ptr_ctrl.sv
// Top pointer and occupancy of the return stack.
// A group moves the pointer up by its push count and down by one on a pop.
// The occupancy saturates at DEPTH when pushes overrun the oldest entry.
// A restore loads both values, with the occupancy clamped, and overrides any group.
module mbfras_ptr_ctrl #(
    parameter int DEPTH = 16,
    parameter int PW    = 4,
    parameter int CW    = 5,
    parameter int NW    = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restore,
    input  logic [PW-1:0]  restore_ptr,
    input  logic [CW-1:0]  restore_cnt,
    input  logic           act,
    input  logic [NW-1:0]  npush,
    input  logic           pop,
    output logic [PW-1:0]  top_ptr,
    output logic [CW-1:0]  cnt
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [CW:0]   sum;
    logic [CW-1:0] sat, cnt_nx;
    logic [PW-1:0] ptr_nx;

    // Next occupancy and pointer for an accepted group.
    always_comb begin
        sum    = {1'b0, cnt} + (CW+1)'(npush);
        sat    = (sum > (CW+1)'(DEPTH)) ? DEPTH_C : sum[CW-1:0];
        cnt_nx = sat - CW'(pop);
        ptr_nx = top_ptr + PW'(npush) - PW'(pop);
    end

    // State register: reset, restore, group update or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_ptr <= '0;
            cnt     <= '0;
        end else if (restore) begin
            top_ptr <= restore_ptr;
            cnt     <= (restore_cnt > DEPTH_C) ? DEPTH_C : restore_cnt;
        end else if (act) begin
            top_ptr <= ptr_nx;
            cnt     <= cnt_nx;
        end
    end

    // R5: the occupancy never exceeds the depth.
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DEPTH_C);

    // R8: a restore lands the tag it was given.
    a_r8_restore_load: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (top_ptr == $past(restore_ptr)) &&
                    (cnt == (($past(restore_cnt) > DEPTH_C) ? DEPTH_C : $past(restore_cnt))));

    // R10: without a group or a restore the state holds.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && !act) |=> ($stable(top_ptr) && $stable(cnt)));
endmodule

// File: rtl/mbfras_top.sv
// Return address stack for a front end fetching up to NBLK basic blocks per
// cycle.
// Pushes every kept call's return address in block order.
// A closing return pops and predicts the newest address, bypassing a push made
// in the same group.
// Reports which slots were kept and whether an indirect jump closed the group.
// Exposes the pre-group pointer and occupancy as a rewind tag.
// Assumes DEPTH is a power of two and NBLK <= DEPTH.
module mbfras_top #(
    parameter int NBLK  = 4,
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NW   = $clog2(NBLK + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grp_valid,
    input  logic [2*NBLK-1:0]   blk_kind,
    input  logic [AW*NBLK-1:0]  blk_ret_addr,
    input  logic                restore_valid,
    input  logic [PW-1:0]       restore_ptr,
    input  logic [CW-1:0]       restore_cnt,
    output logic [NBLK-1:0]     keep_mask,
    output logic                ind_end,
    output logic                ret_pred_valid,
    output logic [AW-1:0]       ret_pred_addr,
    output logic [PW-1:0]       ckpt_ptr,
    output logic [CW-1:0]       ckpt_cnt
);
    logic                act;
    logic [NBLK-1:0]     push;
    logic [NW*NBLK-1:0]  slot;
    logic [NW-1:0]       npush;
    logic                ret_hit;
    logic [AW-1:0]       last_addr;
    logic [PW*NBLK-1:0]  wr_idx;
    logic [AW-1:0]       top_data;
    logic [PW-1:0]       top_ptr;
    logic [CW-1:0]       cnt;
    logic                pop;

    // A group is accepted only when no rewind is requested.
    assign act = grp_valid && !restore_valid;

    mbfras_group_scan #(.NBLK(NBLK), .AW(AW), .NW(NW)) u_scan (
        .grp_act   (act),
        .kinds     (blk_kind),
        .addrs     (blk_ret_addr),
        .keep      (keep_mask),
        .push      (push),
        .slot      (slot),
        .npush     (npush),
        .ret_hit   (ret_hit),
        .ind_hit   (ind_end),
        .last_addr (last_addr)
    );

    // Each push lands at the top pointer plus its slot offset.
    for (genvar g = 0; g < NBLK; g++) begin : g_widx
        assign wr_idx[PW*g +: PW] = top_ptr + PW'(slot[NW*g +: NW]);
    end

    mbfras_stack_store #(.DEPTH(DEPTH), .AW(AW), .NBLK(NBLK), .PW(PW)) u_store (
        .clk     (clk),
        .wr_en   (push),
        .wr_idx  (wr_idx),
        .wr_data (blk_ret_addr),
        .rd_idx  (top_ptr),
        .rd_data (top_data)
    );

    // A pop succeeds when the group pushed something or the stack holds entries.
    assign pop = ret_hit && ((npush != '0) || (cnt != '0));

    // Prediction: bypass the newest same-cycle push, else read the stored top.
    always_comb begin
        ret_pred_valid = pop;
        ret_pred_addr  = (npush != '0) ? last_addr : top_data;
    end

    mbfras_ptr_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW), .NW(NW)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .restore     (restore_valid),
        .restore_ptr (restore_ptr),
        .restore_cnt (restore_cnt),
        .act         (act),
        .npush       (npush),
        .pop         (pop),
        .top_ptr     (top_ptr),
        .cnt         (cnt)
    );

    // Rewind tag: the state in force before this group.
    assign ckpt_ptr = top_ptr;
    assign ckpt_cnt = cnt;

    // R3: the kept slots always form a prefix.
    a_r3_keep_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({1'b0, keep_mask} + {{NBLK{1'b0}}, 1'b1}));

    // R4: an indirect-jump close never carries a prediction.
    a_r4_ind_no_pred: assert property (@(posedge clk) disable iff (!rst_n)
        ind_end |-> !ret_pred_valid);

    // R2: a prediction with no same-cycle push consumes exactly one entry.
    a_r2_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (act && ret_pred_valid && npush == '0) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: tb/tb_mbfras_top.sv
// Self-checking bench: directed corner cases plus seeded random groups,
// compared against a block-by-block reference model.
module tb_mbfras_top;
    localparam int CLK_P = 10;
    localparam int NB = 4;
    localparam int DP = 16;
    localparam int AW = 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             grp_valid;
    logic [2*NB-1:0]  blk_kind;
    logic [AW*NB-1:0] blk_ret_addr;
    logic             restore_valid;
    logic [3:0]       restore_ptr;
    logic [4:0]       restore_cnt;
    logic [NB-1:0]    keep_mask;
    logic             ind_end, ret_pred_valid;
    logic [AW-1:0]    ret_pred_addr;
    logic [3:0]       ckpt_ptr;
    logic [4:0]       ckpt_cnt;

    int nvec = 0;
    int nfail = 0;
    logic [AW-1:0] m_mem [DP];
    logic [3:0]    m_ptr;
    logic [4:0]    m_cnt;

    always #(CLK_P/2) clk = ~clk;

    mbfras_top dut (.*);

    // One check: count it, report a mismatch.
    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle, compare outputs with the model, then commit the model.
    task automatic run_vec(input logic gv, input logic [2*NB-1:0] kd,
                           input logic [AW*NB-1:0] ad, input logic rs,
                           input logic [3:0] rp, input logic [4:0] rc,
                           input string ctx);
        logic [AW-1:0] tm [DP];
        logic [3:0] tp;
        logic [4:0] tc;
        logic [NB-1:0] ek;
        logic epv, eind, open, empty_ret;
        logic [AW-1:0] epa;
        @(negedge clk);
        grp_valid = gv; blk_kind = kd; blk_ret_addr = ad;
        restore_valid = rs; restore_ptr = rp; restore_cnt = rc;
        tm = m_mem; tp = m_ptr; tc = m_cnt;
        ek = '0; epv = 0; eind = 0; epa = '0; open = 1; empty_ret = 0;
        if (rs) begin
            tp = rp;
            tc = (rc > 5'd16) ? 5'd16 : rc;
        end else if (gv) begin
            for (int i = 0; i < NB; i++) begin
                if (open) begin
                    ek[i] = 1'b1;
                    case (kd[2*i +: 2])
                        2'b01: begin
                            tp = tp + 4'd1;
                            tm[tp] = ad[AW*i +: AW];
                            if (tc < 5'd16) tc = tc + 5'd1;
                        end
                        2'b10: begin
                            open = 0;
                            if (tc > 0) begin
                                epv = 1; epa = tm[tp];
                                tp = tp - 4'd1; tc = tc - 5'd1;
                            end else empty_ret = 1;
                        end
                        2'b11: begin open = 0; eind = 1; end
                        default: ;
                    endcase
                end
            end
        end
        #1;
        chk({"R3 ", ctx}, "keep_mask", 64'(keep_mask), 64'(ek));
        chk({"R4 ", ctx}, "ind_end", 64'(ind_end), 64'(eind));
        chk(empty_ret ? {"R6 ", ctx} : {"R2 ", ctx}, "ret_pred_valid",
            64'(ret_pred_valid), 64'(epv));
        if (epv) chk({"R2 ", ctx}, "ret_pred_addr", 64'(ret_pred_addr), 64'(epa));
        chk({"R7 ", ctx}, "ckpt", 64'({ckpt_ptr, ckpt_cnt}), 64'({m_ptr, m_cnt}));
        @(posedge clk);
        m_mem = tm; m_ptr = tp; m_cnt = tc;
    endtask

    // Weighted random kind code.
    function automatic logic [1:0] rnd_kind();
        int r = $urandom % 20;
        if (r < 8) return 2'b00;
        if (r < 14) return 2'b01;
        if (r < 17) return 2'b10;
        return 2'b11;
    endfunction

    // Pack four kind codes, slot 0 first.
    function automatic logic [7:0] kk(input logic [1:0] k0, input logic [1:0] k1,
                                      input logic [1:0] k2, input logic [1:0] k3);
        return {k3, k2, k1, k0};
    endfunction

    // Print the single summary line.
    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [3:0] sp;
        logic [4:0] sc;
        void'($urandom(32'h5eed_1234));
        rst_n = 0; grp_valid = 1; blk_kind = kk(2'b01, 2'b01, 2'b01, 2'b01);
        blk_ret_addr = {4{32'hdead_beef}}; restore_valid = 0;
        restore_ptr = 0; restore_cnt = 0;
        for (int i = 0; i < DP; i++) m_mem[i] = '0;
        m_ptr = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1; grp_valid = 0;
        #1;
        // R9: reset state visible at the ports
        chk("R9", "ckpt after reset", 64'({ckpt_ptr, ckpt_cnt}), 64'(0));
        chk("R9", "outputs idle", 64'({keep_mask, ind_end, ret_pred_valid}), 64'(0));

        // R6: return on an empty stack
        run_vec(1, kk(2'b10, 2'b00, 2'b00, 2'b00), '0, 0, 0, 0, "R6 empty");
        // R1/R2: two pushes, bypassed return, trailing call dropped
        run_vec(1, kk(2'b01, 2'b01, 2'b10, 2'b01),
                {32'hCCCC, 32'h0, 32'hBBBB, 32'hAAAA}, 0, 0, 0, "R1 bypass");
        run_vec(1, kk(2'b10, 2'b00, 2'b00, 2'b00), '0, 0, 0, 0, "R1 order");
        run_vec(1, kk(2'b10, 2'b00, 2'b00, 2'b00), '0, 0, 0, 0, "R6 drained");
        // R4: indirect close, later call ignored
        run_vec(1, kk(2'b01, 2'b11, 2'b01, 2'b10),
                {32'h0, 32'h7777, 32'h0, 32'h1111}, 0, 0, 0, "R4 ind");
        run_vec(1, kk(2'b10, 2'b00, 2'b00, 2'b00), '0, 0, 0, 0, "R4 after");
        // R10: idle cycle with calls on the bus
        run_vec(0, kk(2'b01, 2'b01, 2'b01, 2'b01), {4{32'h5555}}, 0, 0, 0, "R10 idle");
        // R5: 20 pushes, then 17 pops
        for (int g = 0; g < 5; g++)
            run_vec(1, kk(2'b01, 2'b01, 2'b01, 2'b01),
                    {32'(g*4+4), 32'(g*4+3), 32'(g*4+2), 32'(g*4+1)}, 0, 0, 0, "R5 fill");
        for (int p = 0; p < 17; p++)
            run_vec(1, kk(2'b10, 2'b00, 2'b00, 2'b00), '0, 0, 0, 0, "R5 drain");
        // R8: rewind after pushes, with a group on the bus
        run_vec(1, kk(2'b01, 2'b01, 2'b00, 2'b00), {64'h0, 32'h22, 32'h11}, 0, 0, 0, "R8 pre");
        sp = m_ptr; sc = m_cnt;
        run_vec(1, kk(2'b01, 2'b01, 2'b01, 2'b01), {4{32'h99}}, 0, 0, 0, "R8 spec");
        run_vec(1, kk(2'b10, 2'b01, 2'b01, 2'b01), {4{32'h66}}, 1, sp, sc, "R8 restore");
        run_vec(1, kk(2'b10, 2'b00, 2'b00, 2'b00), '0, 0, 0, 0, "R8 after");
        run_vec(0, '0, '0, 1, 4'd3, 5'd25, "R8 clamp");

        // Random groups mixed with occasional rewinds
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] k;
            logic [127:0] a;
            logic rs;
            k = kk(rnd_kind(), rnd_kind(), rnd_kind(), rnd_kind());
            a = {$urandom, $urandom, $urandom, $urandom};
            rs = ($urandom % 33) == 0;
            run_vec(($urandom % 8) != 0, k, a, rs, 4'($urandom), 5'($urandom % 22), "rnd");
        end
        summary();
        $finish;
    end
endmodule